// File: doc/BRIEF.md
# Single-Channel Block Transfer DMA Engine

This block moves a programmed block of data between one peripheral data port and system memory without help from the host processor. The host loads a start address, a unit count and a control word, then sets a start bit. From then on the engine asks for the system bus, moves one byte or one 16-bit word per peripheral request, steps the memory address and counts units down until the block is complete. At the end it raises a sticky completion status and, if enabled, a one-cycle interrupt.

The bus-ownership policy is chosen per transfer. Block mode keeps the bus request high from the first unit to the last. Stealing mode drops the request for one cycle after every unit so that the processor can win the bus back, then asks again. Idle-slot mode keeps the request high but moves a unit only in cycles where the processor marks the bus as unused. In every mode the engine drives memory strobes and a non-zero address only while the grant is high. If the grant is withdrawn partway through a block, the engine waits and then carries on from the same address.

Memory accesses complete in one cycle. The peripheral acknowledge coincides with the memory strobe, so the peripheral either supplies write data in that cycle or captures read data in that cycle.

Top module: `dma_engine`

## Requirements
- R1: After reset the engine is idle. bus_req, mem_rd, mem_wr, dack and irq are low, and all three registers read as zero.
- R2: While idle, host writes load the registers and read back through reg_rdata. Select 0 is the address and select 1 is the count. Select 2 is the control word: bit 0 start (write only, reads 0), bit 1 direction (1 = memory to peripheral), bit 2 unit (1 = 16-bit word), bits 4:3 bus mode (0 block, 1 stealing, 2 idle-slot, 3 behaves as block), bit 5 interrupt enable, bit 6 busy (read only), bit 7 done (read only).
- R3: While busy, host writes to any register are ignored, and the block in progress runs to completion with its original settings.
- R4: Each unit is accessed at the current address, which then advances by 1 in byte mode and by 2 in word mode, wrapping at 16 bits.
- R5: The count holds the number of units minus one and decrements after each unit. The block ends after the unit moved while the count was zero, so the count then reads all ones and bus_req falls.
- R6: Direction 0 writes memory (mem_wr) with the peripheral data. Direction 1 reads memory (mem_rd) and presents the data on per_wdata. In byte mode only bits 7:0 carry data and bits 15:8 are zero. mem_word is high during word accesses.
- R7: In block mode bus_req stays high without a break from the start until the block ends.
- R8: In stealing mode bus_req is low for exactly one cycle after every unit except the last, then rises again.
- R9: In idle-slot mode a unit is moved only in a cycle where bus_idle is high.
- R10: mem_rd, mem_wr and dack are never high, and mem_addr is always zero, unless bus_grant is high and the engine is requesting. When the grant drops, the block suspends with address and count held, and it resumes when the grant returns.
- R11: A unit moves only in a cycle where dreq is high. dack is high for exactly the cycles in which a unit moves, together with one memory strobe.
- R12: Completion sets done, which stays set until the next start. With the interrupt enabled, irq is high for exactly one cycle when the block ends. With it disabled, irq stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| bus_idle | input | 1 | Processor marks the current cycle as bus-free |
| mem_addr | output | 16 | Memory address, zero when the bus is not owned |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_word | output | 1 | High for a 16-bit access |
| mem_wdata | output | 16 | Data written to memory |
| mem_rdata | input | 16 | Data read from memory, same cycle |
| dreq | input | 1 | Peripheral request for one unit |
| dack | output | 1 | Peripheral acknowledge, one cycle per unit |
| per_rdata | input | 16 | Data supplied by the peripheral |
| per_wdata | output | 16 | Data delivered to the peripheral |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach is a grant withdrawn in the middle of a block, because it needs an arbiter that takes the bus back while the engine still wants it. The bench's arbiter model has an enable. The stimulus waits until a chosen number of units have been observed at the ports, clears the enable, and then checks over several cycles that the address and count stay frozen and that no strobe appears before the grant returns. A second hard case is a write to the registers while the engine is busy. This is reached by starting a block with the grant held off, so the engine sits busy for as long as the bench needs. An address run that wraps through zero, and the count's final all-ones value, are covered by vector entries chosen for that purpose.

// File: rtl/dma_engine_pkg.sv
package dma_engine_pkg;

   typedef enum logic [1:0] {
      BUS_BLOCK = 2'd0,
      BUS_STEAL = 2'd1,
      BUS_SLOT  = 2'd2,
      BUS_RSVD  = 2'd3
   } bus_mode_e;

   localparam int SEL_ADDR = 0;
   localparam int SEL_CNT  = 1;
   localparam int SEL_CTRL = 2;

   localparam int CB_START   = 0;
   localparam int CB_DIR     = 1;
   localparam int CB_WORD    = 2;
   localparam int CB_MODE_LO = 3;
   localparam int CB_IRQEN   = 5;
   localparam int CB_BUSY    = 6;
   localparam int CB_DONE    = 7;

   typedef struct packed {
      logic      irq_en;
      bus_mode_e mode;
      logic      word;
      logic      to_periph;
   } xfer_cfg_t;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
   import dma_engine_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int REG_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              unit_move,
   output logic [ADDR_W-1:0] cur_addr,
   output xfer_cfg_t         cfg,
   output logic              busy,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(DATA_W / 8);

   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   xfer_cfg_t         cfg_q;
   xfer_cfg_t         cfg_wr;
   logic              busy_q, done_q, irq_q;
   logic [ADDR_W-1:0] step;
   logic [REG_W-1:0]  ctrl_view;

   wire host_wr  = reg_we && !busy_q;
   wire start_wr = host_wr && (reg_sel == 2'(SEL_CTRL)) && reg_wdata[CB_START];

   always_comb begin
      cfg_wr.to_periph = reg_wdata[CB_DIR];
      cfg_wr.word      = reg_wdata[CB_WORD];
      cfg_wr.mode      = bus_mode_e'(reg_wdata[CB_MODE_LO +: 2]);
      cfg_wr.irq_en    = reg_wdata[CB_IRQEN];
   end

   assign step = cfg_q.word ? STEP_WORD : STEP_BYTE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         cfg_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (host_wr) begin
            unique case (reg_sel)
               2'(SEL_ADDR): addr_q <= reg_wdata[ADDR_W-1:0];
               2'(SEL_CNT):  cnt_q  <= reg_wdata[CNT_W-1:0];
               2'(SEL_CTRL): cfg_q  <= cfg_wr;
               default: ;
            endcase
            if (start_wr) begin
               busy_q <= 1'b1;
               done_q <= 1'b0;
            end
         end else if (unit_move) begin
            addr_q <= addr_q + step;
            cnt_q  <= cnt_q - CNT_W'(1);
            if (cnt_q == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               irq_q  <= cfg_q.irq_en;
            end
         end
      end
   end

   always_comb begin
      ctrl_view               = '0;
      ctrl_view[CB_DIR]       = cfg_q.to_periph;
      ctrl_view[CB_WORD]      = cfg_q.word;
      ctrl_view[CB_MODE_LO +: 2] = cfg_q.mode;
      ctrl_view[CB_IRQEN]     = cfg_q.irq_en;
      ctrl_view[CB_BUSY]      = busy_q;
      ctrl_view[CB_DONE]      = done_q;
      unique case (reg_sel)
         2'(SEL_ADDR): reg_rdata = REG_W'(addr_q);
         2'(SEL_CNT):  reg_rdata = REG_W'(cnt_q);
         2'(SEL_CTRL): reg_rdata = ctrl_view;
         default:      reg_rdata = '0;
      endcase
   end

   assign cur_addr = addr_q;
   assign cfg      = cfg_q;
   assign busy     = busy_q;
   assign irq      = irq_q;

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      unit_move |=> (addr_q == $past(addr_q) + $past(step))); // R4
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> $stable(cfg_q)); // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !unit_move) |=> $stable(cnt_q)); // R11
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q); // R12
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start_wr) |=> done_q); // R12

endmodule

// File: rtl/dma_bus_ctl.sv
module dma_bus_ctl
   import dma_engine_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      busy,
   input  bus_mode_e mode,
   input  logic      bus_grant,
   input  logic      bus_idle,
   input  logic      dreq,
   output logic      bus_req,
   output logic      own,
   output logic      unit_move
);

   logic gap_q;
   logic slot_ok;

   wire stealing = (mode == BUS_STEAL);

   always_comb begin
      unique case (mode)
         BUS_SLOT: slot_ok = bus_idle;
         default:  slot_ok = 1'b1;
      endcase
   end

   assign bus_req   = busy && !(stealing && gap_q);
   assign own       = bus_req && bus_grant;
   assign unit_move = own && dreq && slot_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= 1'b0;
      else        gap_q <= unit_move && stealing;
   end

   AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_move && stealing) |=> !bus_req); // R8
   AST_STEAL_REREQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q && busy) |=> bus_req); // R8
   AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !stealing) |=> (bus_req || !busy)); // R7
   AST_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_move && mode == BUS_SLOT) |-> bus_idle); // R9
   AST_MOVE_PACED: assert property (@(posedge clk) disable iff (!rst_n)
      unit_move |-> (dreq && bus_grant)); // R11

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
   parameter int DATA_W = 16
) (
   input  logic              word,
   input  logic              to_periph,
   input  logic              move,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] per_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] per_wdata
);

   localparam int LANES = DATA_W / 8;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic lane_on;
      if (ln == 0) begin : g_low
         assign lane_on = 1'b1;
      end else begin : g_high
         assign lane_on = word;
      end
      assign mem_wdata[ln*8 +: 8] = (move && !to_periph && lane_on) ? per_rdata[ln*8 +: 8] : 8'h00;
      assign per_wdata[ln*8 +: 8] = (move &&  to_periph && lane_on) ? mem_rdata[ln*8 +: 8] : 8'h00;
   end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
   import dma_engine_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int REG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              bus_req,
   input  logic              bus_grant,
   input  logic              bus_idle,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              mem_word,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              dreq,
   output logic              dack,
   input  logic [DATA_W-1:0] per_rdata,
   output logic [DATA_W-1:0] per_wdata,
   output logic              irq
);

   if (DATA_W < 16 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("dma_engine: DATA_W must be a multiple of 8 and at least 16");
   end
   if (ADDR_W > REG_W || CNT_W > REG_W) begin : g_bad_reg_w
      $error("dma_engine: address and count must fit in REG_W");
   end
   if (REG_W < 8) begin : g_bad_ctrl_w
      $error("dma_engine: REG_W too narrow for the control word");
   end

   logic [ADDR_W-1:0] cur_addr;
   xfer_cfg_t         cfg;
   logic              busy, own, unit_move;

   dma_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .REG_W  (REG_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .unit_move (unit_move),
      .cur_addr  (cur_addr),
      .cfg       (cfg),
      .busy      (busy),
      .irq       (irq)
   );

   dma_bus_ctl u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .mode      (cfg.mode),
      .bus_grant (bus_grant),
      .bus_idle  (bus_idle),
      .dreq      (dreq),
      .bus_req   (bus_req),
      .own       (own),
      .unit_move (unit_move)
   );

   dma_datapath #(
      .DATA_W (DATA_W)
   ) u_data (
      .word      (cfg.word),
      .to_periph (cfg.to_periph),
      .move      (unit_move),
      .mem_rdata (mem_rdata),
      .per_rdata (per_rdata),
      .mem_wdata (mem_wdata),
      .per_wdata (per_wdata)
   );

   assign mem_addr = own ? cur_addr : '0;
   assign mem_word = own && cfg.word;
   assign mem_rd   = unit_move &&  cfg.to_periph;
   assign mem_wr   = unit_move && !cfg.to_periph;
   assign dack     = unit_move;

   AST_NO_BUS_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || dack || mem_addr != '0) |-> bus_grant); // R10
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr})); // R6
   AST_DACK_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      dack == (mem_rd || mem_wr)); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(bus_req || mem_rd || mem_wr)); // R5

endmodule

// File: tb/dma_engine_bench.sv
`timescale 1ns/1ps
module dma_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd2;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        bus_req;
   logic        bus_grant = 1'b0;
   logic        bus_idle = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr, mem_word;
   logic [15:0] mem_wdata, mem_rdata;
   logic        dreq = 1'b1;
   logic        dack;
   logic [15:0] per_rdata, per_wdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   bit          grant_en = 1'b1;
   bit          mon_on = 1'b0;
   logic [15:0] m_base = '0;
   int          m_inc = 1;
   bit          m_dir = 1'b0;
   bit          m_word = 1'b0;
   bit          m_slot = 1'b0;
   int          m_idx = 0;
   int          idle_cnt = 0;

   always #10 clk = ~clk;

   dma_engine u_dma_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_grant(bus_grant), .bus_idle(bus_idle), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dreq(dreq), .dack(dack),
      .per_rdata(per_rdata), .per_wdata(per_wdata), .irq(irq)
   );

   // memory and peripheral models
   assign mem_rdata = mem_addr ^ 16'h5A3C;
   assign per_rdata = {8'hB7, 8'(m_idx) ^ 8'h5C};

   // arbiter: grants one cycle after a request while enabled
   always @(posedge clk) bus_grant <= bus_req && grant_en;

   // processor bus activity: two idle cycles out of three
   always begin
      @(posedge clk);
      #2;
      idle_cnt = idle_cnt + 1;
      bus_idle = (idle_cnt % 3) != 0;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // port monitor, sampled at the falling edge
   always @(negedge clk) begin
      if (mon_on) begin
         if (!bus_grant) begin
            chk(!(mem_rd || mem_wr || dack) && mem_addr == 16'h0, "R10 bus quiet without grant",
                {mem_rd, mem_wr, dack, 13'h0, mem_addr}, 32'h0);
         end
         if (mem_rd || mem_wr || dack) begin
            logic [15:0] ea, er, ew;
            ea = 16'(int'(m_base) + m_idx * m_inc);
            er = ea ^ 16'h5A3C;
            ew = {8'hB7, 8'(m_idx) ^ 8'h5C};
            chk(dack && (mem_rd != mem_wr), "R11 dack with one strobe",
                {dack, mem_rd, mem_wr}, 3'b1);
            chk(mem_addr == ea, "R4 unit address", mem_addr, ea);
            chk(mem_rd == m_dir && mem_word == m_word, "R6 direction and size",
                {mem_rd, mem_word}, {m_dir, m_word});
            if (m_dir)
               chk(per_wdata == (m_word ? er : {8'h00, er[7:0]}), "R6 data to peripheral",
                   per_wdata, m_word ? er : {8'h00, er[7:0]});
            else
               chk(mem_wdata == (m_word ? ew : {8'h00, ew[7:0]}), "R6 data to memory",
                   mem_wdata, m_word ? ew : {8'h00, ew[7:0]});
            if (m_slot) chk(bus_idle, "R9 move only in idle slot", bus_idle, 1);
            chk(dreq, "R11 move paced by dreq", dreq, 1);
            m_idx++;
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      reg_we = 1'b1;
      reg_sel = sel;
      reg_wdata = d;
      tick();
      reg_we = 1'b0;
      reg_sel = 2'd2;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [15:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
      reg_sel = 2'd2;
      #1;
   endtask

   task automatic arm(input logic [15:0] base, input bit dir, input bit word, input bit slot);
      m_base = base; m_dir = dir; m_word = word; m_slot = slot;
      m_inc = word ? 2 : 1; m_idx = 0; mon_on = 1'b1;
   endtask

   // wait for the end of a block; counts request gaps while busy and irq cycles
   task automatic wait_done(output int gaps, output int irqs);
      int cyc;
      gaps = 0; irqs = 0; cyc = 0;
      reg_sel = 2'd2;
      do begin
         @(negedge clk);
         cyc++;
         if (reg_rdata[6] && !bus_req) gaps++;
         if (irq) irqs++;
      end while (reg_rdata[6] && cyc < 4000);
      repeat (2) begin
         @(negedge clk);
         if (irq) irqs++;
      end
      #3;
   endtask

   // mode[55:54] dir[53] word[52] irqen[51] base[47:32] count[31:16] end[15:0]
   localparam logic [55:0] VEC [0:6] = '{
      {2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 16'h1000, 16'd3, 16'h1004},
      {2'd0, 1'b1, 1'b1, 1'b1, 3'd0, 16'h2000, 16'd2, 16'h2006},
      {2'd1, 1'b0, 1'b1, 1'b0, 3'd0, 16'h3000, 16'd3, 16'h3008},
      {2'd1, 1'b1, 1'b0, 1'b1, 3'd0, 16'h40FE, 16'd4, 16'h4103},
      {2'd2, 1'b0, 1'b0, 1'b1, 3'd0, 16'h5000, 16'd5, 16'h5006},
      {2'd2, 1'b1, 1'b1, 1'b0, 3'd0, 16'hFFFC, 16'd3, 16'h0004},
      {2'd3, 1'b0, 1'b1, 1'b1, 3'd0, 16'h0100, 16'd0, 16'h0102}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R5 block never completed actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int gaps, irqs;

      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      tick();
      @(negedge clk);
      chk(!bus_req && !mem_rd && !mem_wr && !dack && !irq, "R1 outputs idle after reset",
          {bus_req, mem_rd, mem_wr, dack, irq}, 0);
      #3;
      rd(2'd0, d); chk(d == 0, "R1 address after reset", d, 0);
      rd(2'd1, d); chk(d == 0, "R1 count after reset", d, 0);
      rd(2'd2, d); chk(d == 0, "R1 control after reset", d, 0);

      // R2: readback while idle, start bit clear
      wr(2'd0, 16'hBEEF);
      wr(2'd1, 16'h0123);
      wr(2'd2, 16'h002E);
      rd(2'd0, d); chk(d == 16'hBEEF, "R2 address readback", d, 16'hBEEF);
      rd(2'd1, d); chk(d == 16'h0123, "R2 count readback", d, 16'h0123);
      rd(2'd2, d); chk(d == 16'h002E, "R2 control readback", d, 16'h002E);
      chk(!bus_req, "R2 no request without start", bus_req, 0);

      // vector table walk
      for (int v = 0; v < 7; v++) begin
         logic [1:0]  mode;
         logic [15:0] base, cnt, endv;
         bit          dir, word, ien;
         int          exp_gaps;
         mode = VEC[v][55:54]; dir = VEC[v][53]; word = VEC[v][52]; ien = VEC[v][51];
         base = VEC[v][47:32]; cnt = VEC[v][31:16]; endv = VEC[v][15:0];
         exp_gaps = (mode == 2'd1) ? int'(cnt) : 0;
         arm(base, dir, word, mode == 2'd2);
         wr(2'd0, base);
         wr(2'd1, cnt);
         wr(2'd2, {10'h0, ien, mode, word, dir, 1'b1});
         wait_done(gaps, irqs);
         chk(m_idx == int'(cnt) + 1, "R5 units moved", m_idx, int'(cnt) + 1);
         rd(2'd0, d); chk(d == endv, "R4 final address", d, endv);
         rd(2'd1, d); chk(d == 16'hFFFF, "R5 count wrapped", d, 16'hFFFF);
         rd(2'd2, d); chk(d[7:6] == 2'b10, "R12 done set and busy clear", d[7:6], 2'b10);
         chk(irqs == int'(ien), "R12 interrupt pulse count", irqs, int'(ien));
         chk(gaps == exp_gaps, (mode == 2'd1) ? "R8 request gaps" : "R7 request held",
             gaps, exp_gaps);
         chk(!bus_req, "R5 request released", bus_req, 0);
      end
      mon_on = 1'b0;

      // R12: done stays set while idle
      repeat (10) tick();
      rd(2'd2, d); chk(d[7] && !irq, "R12 done sticky", {d[7], irq}, 2'b10);

      // R3: writes while busy are ignored (grant held off)
      grant_en = 1'b0;
      arm(16'h0200, 1'b0, 1'b0, 1'b0);
      wr(2'd0, 16'h0200);
      wr(2'd1, 16'h0001);
      wr(2'd2, 16'h0001);
      rd(2'd2, d); chk(d[7] == 1'b0, "R12 done cleared by start", d[7], 0);
      repeat (3) tick();
      chk(bus_req && m_idx == 0, "R10 waiting for grant", {bus_req, 8'(m_idx)}, 9'h100);
      wr(2'd0, 16'h7777);
      wr(2'd1, 16'h0009);
      wr(2'd2, 16'h003E);
      rd(2'd0, d); chk(d == 16'h0200, "R3 address write ignored", d, 16'h0200);
      rd(2'd1, d); chk(d == 16'h0001, "R3 count write ignored", d, 16'h0001);
      rd(2'd2, d); chk(d == 16'h0040, "R3 control write ignored", d, 16'h0040);
      grant_en = 1'b1;
      wait_done(gaps, irqs);
      chk(m_idx == 2 && irqs == 0, "R3 original block completed", {8'(m_idx), 8'(irqs)}, 16'h0200);
      rd(2'd0, d); chk(d == 16'h0202, "R3 original address kept", d, 16'h0202);

      // R10: grant withdrawn mid-block
      arm(16'h6000, 1'b0, 1'b1, 1'b0);
      wr(2'd0, 16'h6000);
      wr(2'd1, 16'h0005);
      wr(2'd2, 16'h0005);
      while (m_idx < 2) @(negedge clk);
      #3;
      grant_en = 1'b0;
      repeat (4) tick();
      begin
         logic [15:0] a1, c1;
         int held;
         rd(2'd0, a1);
         rd(2'd1, c1);
         held = m_idx;
         repeat (6) tick();
         rd(2'd0, d); chk(d == a1, "R10 address held while suspended", d, a1);
         rd(2'd1, d); chk(d == c1, "R10 count held while suspended", d, c1);
         chk(m_idx == held, "R10 no unit while suspended", m_idx, held);
         rd(2'd2, d); chk(d[6], "R10 still busy while suspended", d[6], 1);
      end
      grant_en = 1'b1;
      wait_done(gaps, irqs);
      chk(m_idx == 6, "R10 resumed to completion", m_idx, 6);
      rd(2'd0, d); chk(d == 16'h600C, "R10 final address after resume", d, 16'h600C);

      // R11: no unit without dreq
      dreq = 1'b0;
      arm(16'h0700, 1'b0, 1'b0, 1'b0);
      wr(2'd0, 16'h0700);
      wr(2'd1, 16'h0000);
      wr(2'd2, 16'h0001);
      repeat (6) tick();
      chk(m_idx == 0 && bus_grant, "R11 granted but no dreq, no unit",
          {8'(m_idx), 7'h0, bus_grant}, 16'h0001);
      rd(2'd0, d); chk(d == 16'h0700, "R11 address unchanged without dreq", d, 16'h0700);
      dreq = 1'b1;
      wait_done(gaps, irqs);
      chk(m_idx == 1, "R11 single unit after dreq", m_idx, 1);
      mon_on = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule